// File: doc/BRIEF.md
# Slot Cycle Limit Timer

This block guards one slave port of a bus matrix against a single master holding that port for too long. Every time the port's arbiter completes an arbitration, a down-counter is loaded with a programmable slot length. The counter then decrements once for each clock cycle in which a master owns the port. When it reaches zero the slot has expired, and the counter stays at zero.

An expired slot does not cut the current access short. The block raises its re-arbitration request only in a cycle where the current bus transfer completes (ready high at the end of a transfer). That request is a one-cycle pulse, and it is not repeated until the next arbitration reloads the counter.

A slot length of zero turns the limit off. The slot length register holds its all-ones maximum after reset. A new value written to it is used at the next reload and does not alter a count already in progress. Master selection and priority belong to the arbiter, not to this block.

Top module: `slot_limit_timer`

## Requirements
- R1: After reset the slot length register holds all ones (255 for the default 8-bit width), and rearb_req stays low until the first arb_done.
- R2: When arb_done is high at a clock edge, the counter loads the slot length N held at that moment. The slot expires once N further edges have occurred with port_busy high and arb_done low.
- R3: Cycles with port_busy low do not decrement the counter, so they do not shorten the slot.
- R4: rearb_req is high only in a cycle where the slot has expired and xfer_end is high. An expired slot keeps waiting at zero, however long xfer_end stays low.
- R5: After one rearb_req pulse there is no further rearb_req until a later arb_done has reloaded the counter.
- R6: Loading a slot length of 0 disables the timer, so no rearb_req occurs until a nonzero length is loaded.
- R7: A write to the slot length register (cfg_wr high at an edge) is used only from the next arb_done onward. It does not change the count in progress.
- R8: In a cycle where arb_done is high, rearb_req is low, because the reload takes priority over a pending expiry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_wr | input | 1 | Write strobe for the slot length register |
| cfg_wdata | input | CNT_W | New slot length in cycles (0 disables the timer) |
| arb_done | input | 1 | The arbiter completed an arbitration in this cycle |
| port_busy | input | 1 | A master currently owns the slave port |
| xfer_end | input | 1 | The current transfer completes in this cycle (ready high) |
| rearb_req | output | 1 | One-cycle request for the arbiter to re-arbitrate |

## Verification
rearb_req depends combinationally on xfer_end and arb_done in the same cycle, together with the registered count and state. The bench therefore changes its inputs at the falling edge and compares rearb_req 1 ns later, in the same cycle. The effects of arb_done, cfg_wr and port_busy appear only after the next rising edge. The bench's model applies those updates right after that edge, so every expected value lags its stimulus by exactly one register stage. Directed sequences cover the all-ones default, long waits for a transfer end, idle stretches, zero length, writes in the middle of a count and a reload in the same cycle as an expiry. Seeded random traffic covers the rest.

// File: rtl/slot_limit_pkg.sv
// Shared types for the slot cycle limit timer.
package slot_limit_pkg;
    // Timer state: OFF means disabled, already fired, or not yet loaded.
    typedef enum logic {
        SLOT_OFF = 1'b0,
        SLOT_RUN = 1'b1
    } slot_state_e;
endpackage

// File: rtl/slot_cfg_reg.sv
// Slot length register.
// Holds the programmed slot length, which resets to the all-ones maximum.
// Assumes writes are single-cycle strobes. The value is only sampled at a reload.
module slot_cfg_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] cfg_q
);
    // Capture a new slot length, or restore the maximum on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= '1;
        else if (wr_en)
            cfg_q <= wr_data;
    end
endmodule

// File: rtl/slot_down_counter.sv
// Saturating down-counter.
// A load has priority over decrement. The count holds once it reaches zero.
// Assumes dec_en is already qualified by the caller (port owned, timer running).
module slot_down_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec_en,
    output logic [W-1:0] cnt_q,
    output logic         is_zero
);
    localparam logic [W-1:0] ONE = W'(1);

    // Load, decrement, or hold the remaining slot cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (dec_en && (cnt_q != '0))
            cnt_q <= cnt_q - ONE;
    end

    // Flag an exhausted count.
    always_comb is_zero = (cnt_q == '0);
endmodule

// File: rtl/slot_req_gen.sv
// Request generator.
// Tracks whether a slot is being timed and issues one re-arbitration pulse
// when the slot is exhausted and the current transfer ends.
// Assumes arb_done marks the cycle in which ownership is (re)granted.
module slot_req_gen
    import slot_limit_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arb_done,
    input  logic len_is_zero,
    input  logic port_busy,
    input  logic xfer_end,
    input  logic cnt_zero,
    output logic dec_en,
    output logic rearb_req
);
    slot_state_e state_q;

    // Enter RUN on a reload with a nonzero length. Leave it after firing.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= SLOT_OFF;
        else if (arb_done)
            state_q <= len_is_zero ? SLOT_OFF : SLOT_RUN;
        else if (rearb_req)
            state_q <= SLOT_OFF;
    end

    // Count only while the slot runs and a master owns the port.
    always_comb dec_en = (state_q == SLOT_RUN) && port_busy && !arb_done;

    // Request at the end of a transfer once the slot is exhausted. A reload wins.
    always_comb rearb_req = (state_q == SLOT_RUN) && cnt_zero && xfer_end && !arb_done;
endmodule

// File: rtl/slot_limit_timer.sv
// Slot cycle limit timer for one slave port of a bus matrix.
// Loads the programmed slot length at each arbitration and counts the cycles
// in which the port is owned. When the slot is used up, it asks for
// re-arbitration at the next transfer end. A length of zero disables it.
// Assumes arb_done, port_busy and xfer_end are synchronous to clk.
module slot_limit_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [CNT_W-1:0] cfg_wdata,
    input  logic             arb_done,
    input  logic             port_busy,
    input  logic             xfer_end,
    output logic             rearb_req
);
    logic [CNT_W-1:0] cfg_q;
    logic [CNT_W-1:0] cnt_q;
    logic             cnt_zero;
    logic             dec_en;
    logic             len_is_zero;

    // Detect a disabling (zero) slot length at reload time.
    always_comb len_is_zero = (cfg_q == '0);

    slot_cfg_reg #(.W(CNT_W)) cfg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr),
        .wr_data (cfg_wdata),
        .cfg_q   (cfg_q)
    );

    slot_down_counter #(.W(CNT_W)) cnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (arb_done),
        .load_val (cfg_q),
        .dec_en   (dec_en),
        .cnt_q    (cnt_q),
        .is_zero  (cnt_zero)
    );

    slot_req_gen req_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .arb_done    (arb_done),
        .len_is_zero (len_is_zero),
        .port_busy   (port_busy),
        .xfer_end    (xfer_end),
        .cnt_zero    (cnt_zero),
        .dec_en      (dec_en),
        .rearb_req   (rearb_req)
    );
endmodule

// File: rtl/slot_limit_timer_chk.sv
// Property checker for slot_limit_timer, attached with bind.
// Watches the ports plus the internal slot length and count.
module slot_limit_timer_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             arb_done,
    input logic             port_busy,
    input logic             xfer_end,
    input logic             rearb_req,
    input logic [CNT_W-1:0] cfg_q,
    input logic [CNT_W-1:0] cnt_q
);
    // R4: a request only ever coincides with a transfer end.
    a_r4_req_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        rearb_req |-> xfer_end);

    // R5: a request is a single-cycle pulse.
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rearb_req |=> !rearb_req);

    // R8: a reload suppresses the request.
    a_r8_reload_wins: assert property (@(posedge clk) disable iff (!rst_n)
        arb_done |-> !rearb_req);

    // R6: loading a zero length gives no request in the following cycle.
    a_r6_zero_disables: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_done && cfg_q == '0) |=> !rearb_req);

    // R3: an idle port leaves the count unchanged.
    a_r3_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!port_busy && !arb_done) |=> $stable(cnt_q));

    // R2: a reload captures the programmed length.
    a_r2_reload_value: assert property (@(posedge clk) disable iff (!rst_n)
        arb_done |=> (cnt_q == $past(cfg_q)));
endmodule

bind slot_limit_timer slot_limit_timer_chk #(.CNT_W(CNT_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .arb_done  (arb_done),
    .port_busy (port_busy),
    .xfer_end  (xfer_end),
    .rearb_req (rearb_req),
    .cfg_q     (cfg_q),
    .cnt_q     (cnt_q)
);

// File: tb/slot_limit_timer_tb_top.sv
// Self-checking bench for slot_limit_timer: directed corner cases plus seeded random traffic.
module slot_limit_timer_tb_top;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_wr = 1'b0;
    logic [CNT_W-1:0] cfg_wdata = '0;
    logic             arb_done = 1'b0;
    logic             port_busy = 1'b0;
    logic             xfer_end = 1'b0;
    logic             rearb_req;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Reference state kept by the bench, written from the requirements.
    logic [CNT_W-1:0] m_len;
    logic [CNT_W-1:0] m_cnt;
    bit               m_run;

    always #2.5 clk = ~clk;  // 200 MHz

    slot_limit_timer #(.CNT_W(CNT_W)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .arb_done  (arb_done),
        .port_busy (port_busy),
        .xfer_end  (xfer_end),
        .rearb_req (rearb_req)
    );

    // Expected request this cycle (R4, R8).
    function automatic bit exp_req(bit arb, bit xend);
        return m_run && (m_cnt == '0) && xend && !arb;
    endfunction

    task automatic check(string tag, bit exp);
        n_vec++;
        if (rearb_req !== exp) begin
            n_bad++;
            $display("FAIL %s: rearb_req=%0b expected %0b at %0t", tag, rearb_req, exp, $time);
        end
    endtask

    // One cycle: drive at negedge, check 1 ns later, update the model after the rising edge.
    task automatic cyc(bit arb, bit busy, bit xend, bit wr, logic [CNT_W-1:0] wd, string tag);
        bit e;
        @(negedge clk);
        arb_done = arb; port_busy = busy; xfer_end = xend; cfg_wr = wr; cfg_wdata = wd;
        #1;
        e = exp_req(arb, xend);
        check(tag, e);
        @(posedge clk);
        if (arb) begin
            m_cnt = m_len;
            m_run = (m_len != '0);
        end else begin
            if (e) m_run = 1'b0;
            if (m_run && busy && m_cnt != '0) m_cnt = m_cnt - 1'b1;
        end
        if (wr) m_len = wd;
    endtask

    initial begin
        m_len = '1; m_cnt = '0; m_run = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: no request before the first arbitration, even at transfer ends.
        for (int i = 0; i < 5; i++) cyc(0, 1, 1, 0, 0, "R1");
        // R1/R2: default length of 255 is used at the first reload.
        cyc(1, 1, 0, 0, 0, "R2");
        for (int i = 0; i < 254; i++) cyc(0, 1, i[0], 0, 0, "R1");
        cyc(0, 1, 0, 0, 0, "R2");
        // R4: expired and waiting, no transfer end yet.
        for (int i = 0; i < 10; i++) cyc(0, 1, 0, 0, 0, "R4");
        cyc(0, 1, 1, 0, 0, "R4");
        // R5: no repeat while transfer ends keep coming.
        for (int i = 0; i < 8; i++) cyc(0, 1, 1, 0, 0, "R5");

        // R3: idle cycles stretch the slot.
        cyc(0, 1, 0, 1, 8'd4, "R3");
        cyc(1, 1, 0, 0, 0, "R3");
        for (int i = 0; i < 6; i++) cyc(0, 0, 1, 0, 0, "R3");
        for (int i = 0; i < 5; i++) cyc(0, 1, 1, 0, 0, "R3");

        // R6: zero length disables the timer.
        cyc(0, 1, 0, 1, 8'd0, "R6");
        cyc(1, 1, 0, 0, 0, "R6");
        for (int i = 0; i < 300; i++) cyc(0, 1, 1, 0, 0, "R6");

        // R7: a write during a count does not change that count.
        cyc(0, 1, 0, 1, 8'd6, "R7");
        cyc(1, 1, 0, 0, 0, "R7");
        cyc(0, 1, 0, 1, 8'd40, "R7");
        for (int i = 0; i < 8; i++) cyc(0, 1, 1, 0, 0, "R7");

        // R8: a reload in the same cycle as a pending expiry suppresses the request.
        cyc(0, 1, 0, 1, 8'd2, "R8");
        cyc(1, 1, 0, 0, 0, "R8");
        for (int i = 0; i < 3; i++) cyc(0, 1, 0, 0, 0, "R8");
        cyc(1, 1, 1, 0, 0, "R8");
        for (int i = 0; i < 4; i++) cyc(0, 1, 1, 0, 0, "R8");

        // Random traffic across all requirements (R2..R8).
        void'($urandom(32'h5107_c1c1));
        for (int i = 0; i < 6000; i++) begin
            bit a, b, x, w;
            logic [CNT_W-1:0] d;
            a = ($urandom % 25) == 0;
            b = ($urandom % 5) != 0;
            x = ($urandom % 2) == 0;
            w = ($urandom % 30) == 0;
            d = (($urandom % 8) == 0) ? CNT_W'($urandom) : CNT_W'($urandom % 10);
            cyc(a, b, x, w, d, "R2");
        end
        done = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_bad++;
                $display("FAIL watchdog: bench timed out, actual running expected finished");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule